// File: doc/BRIEF.md
# Self-Test Fault Collector

This block gathers the error events of a built-in self-test controller into a bank of sticky status bits, one bit per fault index. A failed test signature is counted only while a self-test run is in progress. A static configuration input sends it either to index 6, the unrecoverable path, or to index 7, the recoverable path. A separate monitor raises index 8 when any memory-test control line goes active while no self-test run is in progress, which means the application is running. Two mirrored flags on the self-test side follow indices 6 and 7. Software clears a collector bit and, through it, the matching flag.

Software can check the whole reaction path without a real failure. It writes a fault code to the injection port, and that sets the same bit and flag that a real event would set. Each fault index has a reaction-select bit. That bit sends a pending fault either to the reset request toward the reset manager or to the interrupt request toward the interrupt controller. Both requests are registered and change on the same clock edge as the status bits.

Top module: `stf_collector`

## Requirements
- R1: Synchronous reset clears every status bit, both self-test flags, every reaction-select bit (all faults route to interrupt), `rst_req_o` and `irq_o`.
- R2: With `bist_active_i` high, `sig_fail_i` high sets status bit 6 when `cfg_unrec_i` is 1, or status bit 7 when it is 0. The bit is visible one clock after the sampling edge.
- R3: While `bist_active_i` is low, `sig_fail_i` has no effect on any status bit or flag.
- R4: Any bit of `mbist_ctrl_i` high while `bist_active_i` is low sets status bit 8. While `bist_active_i` is high, `mbist_ctrl_i` has no effect.
- R5: An injection write (`inj_we_i`) with code 6, 7 or 8 sets status bit 6, 7 or 8. Any other code changes nothing.
- R6: `unrec_flag_o` is set together with status bit 6, and `rec_flag_o` together with status bit 7. Status bit 8 has no mirrored flag.
- R7: A clear write (`clr_we_i`) clears each status bit whose mask bit is 1 and leaves the others alone. Clearing bit 6 or bit 7 also clears its mirrored flag.
- R8: When a set and a clear reach the same status bit in the same cycle, the bit (and its flag) end up set.
- R9: A reaction-select bit of 1 routes its fault to reset and 0 routes it to interrupt. `rst_req_o` is the OR of the set status bits routed to reset. `irq_o` is the OR of the set status bits routed to interrupt. Both update on the same edge as the status and select bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_active_i | input | 1 | High while a self-test run is in progress |
| sig_fail_i | input | 1 | Self-test signature mismatch |
| cfg_unrec_i | input | 1 | 1: signature failure is unrecoverable (index 6); 0: recoverable (index 7) |
| mbist_ctrl_i | input | MB_W | Memory self-test control lines |
| inj_we_i | input | 1 | Fault injection write strobe |
| inj_code_i | input | CODE_W | Fault code to inject |
| clr_we_i | input | 1 | Write-one-to-clear strobe |
| clr_mask_i | input | N_FLT | Status bits to clear |
| react_we_i | input | 1 | Reaction-select write strobe |
| react_data_i | input | N_FLT | New reaction-select bits (1 reset, 0 interrupt) |
| status_o | output | N_FLT | Sticky fault status |
| unrec_flag_o | output | 1 | Self-test unrecoverable flag |
| rec_flag_o | output | 1 | Self-test recoverable flag |
| rst_req_o | output | 1 | Reset request |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a set and a clear landing on the same status bit in the same cycle while the other paths are also active. Examples are a signature failure during a run together with a clear of bit 6, or a control-line glitch outside a run together with a clear of bit 8. The bench drives these collisions on purpose in directed steps. A long random phase then biases the strobes so that set, clear and reaction-select writes often coincide. A behavioural model checks every cycle and catches any priority slip.

// File: rtl/stf_pkg.sv
package stf_pkg;
  // Fault indices; the injection codes equal these indices.
  localparam int unsigned FLT_UNREC = 6;
  localparam int unsigned FLT_REC   = 7;
  localparam int unsigned FLT_MBIST = 8;
  localparam int unsigned FLT_MIN_W = FLT_MBIST + 1;
endpackage

// File: rtl/stf_event_detect.sv
module stf_event_detect #(
  parameter int unsigned N_FLT = 16,
  parameter int unsigned MB_W  = 4
) (
  input  logic             bist_active_i,
  input  logic             sig_fail_i,
  input  logic             cfg_unrec_i,
  input  logic [MB_W-1:0]  mbist_ctrl_i,
  output logic [N_FLT-1:0] hw_set_o
);
  import stf_pkg::*;

  always_comb begin
    hw_set_o = '0;
    // Signature failures only count during a self-test run.
    if (bist_active_i && sig_fail_i) begin
      if (cfg_unrec_i) hw_set_o[FLT_UNREC] = 1'b1;
      else             hw_set_o[FLT_REC]   = 1'b1;
    end
    // Memory-test control seen while the application runs.
    if (!bist_active_i && (|mbist_ctrl_i)) hw_set_o[FLT_MBIST] = 1'b1;
  end
endmodule

// File: rtl/stf_inject_decode.sv
module stf_inject_decode #(
  parameter int unsigned N_FLT  = 16,
  parameter int unsigned CODE_W = 8
) (
  input  logic              inj_we_i,
  input  logic [CODE_W-1:0] inj_code_i,
  output logic [N_FLT-1:0]  inj_set_o
);
  import stf_pkg::*;

  for (genvar i = 0; i < N_FLT; i++) begin : g_dec
    if (i == FLT_UNREC || i == FLT_REC || i == FLT_MBIST) begin : g_live
      assign inj_set_o[i] = inj_we_i && (inj_code_i == CODE_W'(i));
    end else begin : g_dead
      assign inj_set_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/stf_status_bank.sv
module stf_status_bank #(
  parameter int unsigned N_FLT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_FLT-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [N_FLT-1:0] clr_mask_i,
  output logic [N_FLT-1:0] stat_nxt_o,
  output logic [N_FLT-1:0] status_o
);
  for (genvar i = 0; i < N_FLT; i++) begin : g_bit
    // Set has priority over a same-cycle clear.
    assign stat_nxt_o[i] = set_i[i] | (status_o[i] & ~(clr_we_i & clr_mask_i[i]));

    always_ff @(posedge clk) begin
      if (rst) status_o[i] <= 1'b0;
      else     status_o[i] <= stat_nxt_o[i];
    end

    AST_W1C_ONLY: assert property (@(posedge clk) disable iff (rst)
      $fell(status_o[i]) |-> $past(clr_we_i && clr_mask_i[i])); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> status_o[i]); // R8
  end
endmodule

// File: rtl/stf_selftest_flags.sv
module stf_selftest_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_unrec_i,
  input  logic set_rec_i,
  input  logic clr_unrec_i,
  input  logic clr_rec_i,
  output logic unrec_flag_o,
  output logic rec_flag_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      unrec_flag_o <= 1'b0;
      rec_flag_o   <= 1'b0;
    end else begin
      if (set_unrec_i)      unrec_flag_o <= 1'b1;
      else if (clr_unrec_i) unrec_flag_o <= 1'b0;
      if (set_rec_i)        rec_flag_o   <= 1'b1;
      else if (clr_rec_i)   rec_flag_o   <= 1'b0;
    end
  end

  AST_FLAG_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(unrec_flag_o) |-> $past(clr_unrec_i)); // R7
endmodule

// File: rtl/stf_reaction.sv
module stf_reaction #(
  parameter int unsigned N_FLT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             react_we_i,
  input  logic [N_FLT-1:0] react_data_i,
  input  logic [N_FLT-1:0] stat_nxt_i,
  output logic [N_FLT-1:0] react_o,
  output logic             rst_req_o,
  output logic             irq_o
);
  logic [N_FLT-1:0] react_nxt;

  assign react_nxt = react_we_i ? react_data_i : react_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      react_o   <= '0;
      rst_req_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      react_o   <= react_nxt;
      rst_req_o <= |(stat_nxt_i & react_nxt);
      irq_o     <= |(stat_nxt_i & ~react_nxt);
    end
  end
endmodule

// File: rtl/stf_collector.sv
module stf_collector #(
  parameter int unsigned N_FLT  = 16,  // must be at least 9
  parameter int unsigned MB_W   = 4,
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bist_active_i,
  input  logic              sig_fail_i,
  input  logic              cfg_unrec_i,
  input  logic [MB_W-1:0]   mbist_ctrl_i,
  input  logic              inj_we_i,
  input  logic [CODE_W-1:0] inj_code_i,
  input  logic              clr_we_i,
  input  logic [N_FLT-1:0]  clr_mask_i,
  input  logic              react_we_i,
  input  logic [N_FLT-1:0]  react_data_i,
  output logic [N_FLT-1:0]  status_o,
  output logic              unrec_flag_o,
  output logic              rec_flag_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  import stf_pkg::*;

  logic [N_FLT-1:0] hw_set, inj_set, set_all, stat_nxt, react_q;

  stf_event_detect #(.N_FLT(N_FLT), .MB_W(MB_W)) u_detect (
    .bist_active_i(bist_active_i), .sig_fail_i(sig_fail_i),
    .cfg_unrec_i(cfg_unrec_i), .mbist_ctrl_i(mbist_ctrl_i),
    .hw_set_o(hw_set)
  );

  stf_inject_decode #(.N_FLT(N_FLT), .CODE_W(CODE_W)) u_inject (
    .inj_we_i(inj_we_i), .inj_code_i(inj_code_i), .inj_set_o(inj_set)
  );

  assign set_all = hw_set | inj_set;

  stf_status_bank #(.N_FLT(N_FLT)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_all), .clr_we_i(clr_we_i),
    .clr_mask_i(clr_mask_i), .stat_nxt_o(stat_nxt), .status_o(status_o)
  );

  stf_selftest_flags u_flags (
    .clk(clk), .rst(rst),
    .set_unrec_i(set_all[FLT_UNREC]), .set_rec_i(set_all[FLT_REC]),
    .clr_unrec_i(clr_we_i && clr_mask_i[FLT_UNREC]),
    .clr_rec_i(clr_we_i && clr_mask_i[FLT_REC]),
    .unrec_flag_o(unrec_flag_o), .rec_flag_o(rec_flag_o)
  );

  stf_reaction #(.N_FLT(N_FLT)) u_react (
    .clk(clk), .rst(rst), .react_we_i(react_we_i), .react_data_i(react_data_i),
    .stat_nxt_i(stat_nxt), .react_o(react_q), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  AST_UNREC_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (unrec_flag_o == status_o[FLT_UNREC]) && (rec_flag_o == status_o[FLT_REC])); // R6
  AST_REC_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[FLT_REC]) |-> $past((bist_active_i && sig_fail_i && !cfg_unrec_i)
                                       || (inj_we_i && inj_code_i == CODE_W'(FLT_REC)))); // R3
  AST_MB_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[FLT_MBIST]) |-> $past((!bist_active_i && |mbist_ctrl_i)
                                         || (inj_we_i && inj_code_i == CODE_W'(FLT_MBIST)))); // R4
  AST_BAD_CODE_INERT: assert property (@(posedge clk) disable iff (rst)
    (inj_we_i && inj_code_i != CODE_W'(FLT_UNREC) && inj_code_i != CODE_W'(FLT_REC)
     && inj_code_i != CODE_W'(FLT_MBIST) && !sig_fail_i && mbist_ctrl_i == '0 && !clr_we_i)
    |=> $stable(status_o)); // R5
  AST_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (irq_o == |(status_o & ~react_q)) && (rst_req_o == |(status_o & react_q))); // R9
endmodule

// File: tb/stf_collector_tb.sv
module stf_collector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_FLT = 16;
  localparam int MB_W = 4;
  localparam int CODE_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bist_active = 0, sig_fail = 0, cfg_unrec = 0, inj_we = 0, clr_we = 0, react_we = 0;
  logic [MB_W-1:0] mbist = '0;
  logic [CODE_W-1:0] inj_code = '0;
  logic [N_FLT-1:0] clr_mask = '0, react_data = '0;
  logic [N_FLT-1:0] status;
  logic unrec_flag, rec_flag, rst_req, irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // Behavioural model state
  bit [N_FLT-1:0] m_stat, m_react;

  always #(CLK_PERIOD/2) clk = ~clk;

  stf_collector #(.N_FLT(N_FLT), .MB_W(MB_W), .CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst(rst), .bist_active_i(bist_active), .sig_fail_i(sig_fail),
    .cfg_unrec_i(cfg_unrec), .mbist_ctrl_i(mbist), .inj_we_i(inj_we),
    .inj_code_i(inj_code), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .react_we_i(react_we), .react_data_i(react_data), .status_o(status),
    .unrec_flag_o(unrec_flag), .rec_flag_o(rec_flag), .rst_req_o(rst_req), .irq_o(irq)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check(status == m_stat, "R7 status vs model", status, m_stat);
    check(unrec_flag == m_stat[6], "R6 unrec flag vs model", unrec_flag, m_stat[6]);
    check(rec_flag == m_stat[7], "R6 rec flag vs model", rec_flag, m_stat[7]);
    check(irq == |(m_stat & ~m_react), "R9 irq vs model", irq, |(m_stat & ~m_react));
    check(rst_req == |(m_stat & m_react), "R9 rst_req vs model", rst_req, |(m_stat & m_react));
  endtask

  // Apply current inputs for one clock, advance the model, then compare.
  task automatic step();
    bit [N_FLT-1:0] setv;
    setv = '0;
    if (bist_active && sig_fail) setv[cfg_unrec ? 6 : 7] = 1'b1;
    if (!bist_active && mbist != 0) setv[8] = 1'b1;
    if (inj_we && inj_code >= 6 && inj_code <= 8) setv[inj_code] = 1'b1;
    @(posedge clk);
    #2;
    m_stat = (m_stat & ~(clr_we ? clr_mask : '0)) | setv;
    if (react_we) m_react = react_data;
    compare_all();
  endtask

  task automatic idle();
    bist_active = 0; sig_fail = 0; cfg_unrec = 0; mbist = '0;
    inj_we = 0; inj_code = '0; clr_we = 0; clr_mask = '0; react_we = 0; react_data = '0;
  endtask

  task automatic clear_all();
    idle(); clr_we = 1; clr_mask = '1; step(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    m_stat = '0; m_react = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    #2;
    rst = 0;
    // R1: reset state
    check(status == 0 && !unrec_flag && !rec_flag && !irq && !rst_req,
          "R1 reset state", {status, unrec_flag, rec_flag, irq, rst_req}, 0);

    // R2 / R6: unrecoverable signature fail during a run
    bist_active = 1; sig_fail = 1; cfg_unrec = 1; step(); idle();
    check(status == 16'h0040 && unrec_flag && !rec_flag, "R2 sig fail -> bit6", status, 16'h0040);
    check(irq, "R9 bit6 routes to irq by default", irq, 1);
    // R7: clear bit 6 clears the flag
    clr_we = 1; clr_mask = 16'h0040; step(); idle();
    check(status == 0 && !unrec_flag, "R7 W1C bit6 and flag", {status, unrec_flag}, 0);

    // R2 / R6: recoverable
    bist_active = 1; sig_fail = 1; cfg_unrec = 0; step(); idle();
    check(status == 16'h0080 && rec_flag && !unrec_flag, "R2 sig fail -> bit7", status, 16'h0080);
    // R3: sig fail outside run ignored
    sig_fail = 1; cfg_unrec = 1; step(); sig_fail = 1; cfg_unrec = 0; step(); idle();
    check(status == 16'h0080 && !unrec_flag, "R3 sig fail ignored outside run", status, 16'h0080);
    // R7: mask bit 0 leaves bit 7
    clr_we = 1; clr_mask = 16'hFF7F; step(); idle();
    check(status == 16'h0080 && rec_flag, "R7 unmasked bit kept", status, 16'h0080);
    clear_all();
    check(!rec_flag, "R7 clearing bit7 clears rec flag", rec_flag, 0);

    // R4: memory test control outside a run
    mbist = 4'b0010; step(); idle();
    check(status == 16'h0100 && !unrec_flag && !rec_flag, "R4 mbist -> bit8, R6 no flag", status, 16'h0100);
    clear_all();
    bist_active = 1; mbist = 4'b1111; step(); idle();
    check(status == 0, "R4 mbist ignored during run", status, 0);

    // R5: injection by code
    inj_we = 1; inj_code = 8'd6; step();
    inj_code = 8'd7; step();
    inj_code = 8'd8; step(); idle();
    check(status == 16'h01C0 && unrec_flag && rec_flag, "R5 inject 6,7,8", status, 16'h01C0);
    clear_all();
    inj_we = 1; inj_code = 8'd5; step();
    inj_code = 8'd9; step();
    inj_code = 8'h86; step();
    inj_code = 8'd0; step(); idle();
    check(status == 0 && !irq && !rst_req, "R5 bad codes inert", status, 0);

    // R8: set and clear same cycle
    inj_we = 1; inj_code = 8'd6; step(); idle();
    bist_active = 1; sig_fail = 1; cfg_unrec = 1; clr_we = 1; clr_mask = 16'h0040; step(); idle();
    check(status == 16'h0040 && unrec_flag, "R8 set wins over clear", status, 16'h0040);
    mbist = 4'b0001; clr_we = 1; clr_mask = 16'h0100; step(); idle();
    check(status[8], "R8 bit8 set wins over clear", status[8], 1);

    // R9: routing
    react_we = 1; react_data = 16'h0100; step(); idle();
    check(rst_req && irq, "R9 bit8 to reset, bit6 to irq", {rst_req, irq}, 2'b11);
    clr_we = 1; clr_mask = 16'h0040; step(); idle();
    check(rst_req && !irq, "R9 only reset left", {rst_req, irq}, 2'b10);
    react_we = 1; react_data = 16'h0000; step(); idle();
    check(!rst_req && irq, "R9 reroute to irq same edge", {rst_req, irq}, 2'b01);
    clear_all();

    // Random phase with collisions
    for (int n = 0; n < 3000; n++) begin
      bist_active = ($urandom % 2) == 0;
      sig_fail = ($urandom % 4) == 0;
      cfg_unrec = $urandom % 2;
      mbist = (($urandom % 5) == 0) ? MB_W'($urandom) : '0;
      inj_we = ($urandom % 5) == 0;
      inj_code = CODE_W'(4 + ($urandom % 7));
      clr_we = ($urandom % 3) == 0;
      clr_mask = N_FLT'($urandom);
      react_we = ($urandom % 8) == 0;
      react_data = N_FLT'($urandom);
      step();
    end
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule